// File: doc/BRIEF.md
# VS-level interrupt CSR unit

This block holds the hypervisor-side virtual interrupt state of one hart with a 64-bit interrupt space. It serves four read-modify-write CSR views: the virtual-interrupt enable mask, the hypervisor virtual pending register, and the guest's own enable and pending registers. Each access gives a CSR number, a new value and a write mask. The old value of the selected view comes back in the same cycle. The masked update takes effect at the next rising clock edge.

For every bit, the block decides whether the guest sees the machine-level pending or enable state or the hypervisor's separate storage. The decision uses the delegation mask and the virtual-enable mask. The machine pending and enable registers live outside the block. The block reads them on input ports and writes them through mask/data side ports, which the owner of that storage applies at the same clock edge. The three guest-level interrupts keep their machine positions 2, 6 and 10 but appear one position lower in the guest's view. When the separately stored pending bits are written, a strobe tells the interrupt logic to evaluate pending status again.

Top module: `vsIrqCsr`

## Requirements
- R1: The virtual-enable view (CSR 0x608) stores only bits 13..63. Bits 0..12 always read zero and ignore writes.
- R2: In the hypervisor pending view (CSR 0x645), bits 2, 6 and 10 are read from and written to the machine pending side port. A bit in 13..63 uses separate storage when its delegation bit is 0 and its virtual-enable bit is 1, and uses the machine pending side port otherwise. All other bits read zero and ignore writes.
- R3: For bits 13..63 of the guest pending view (CSR 0x244), the source is chosen per bit. A delegated bit aliases machine pending. An undelegated bit with virtual-enable 1 aliases the separate hypervisor pending storage. An undelegated bit with virtual-enable 0 reads zero and ignores writes.
- R4: In both guest views, machine bits 2, 6 and 10 appear at guest bits 1, 5 and 9. Writes move them up one position and reads move them down one. All other bits keep their positions.
- R5: A guest-view bit at 1, 5 or 9 reads zero and ignores writes when delegation bit 2, 6 or 10 (respectively) is 0.
- R6: In the guest pending view, only guest bit 1 and bits 13..63 are writable.
- R7: In the guest enable view (CSR 0x204), delegated bits among 2, 6, 10 and 13..63 alias machine enable through its side port. Undelegated bits in 13..63 with virtual-enable 1 use separate storage. All others read zero.
- R8: `pendChanged` is high in the cycle of any access whose write mask reaches the separate hypervisor pending storage. When it is low, that storage does not change.
- R9: `csrRdata` carries the value from before the write. The update is visible from the next cycle on. An access with a zero write mask, or no access, changes no state.
- R10: A valid access to any other CSR number raises `csrErr`, returns zero and changes no state, including the side ports.
- R11: After reset, all internal storage is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | Access request this cycle |
| csrNum | input | 12 | CSR number of the access |
| csrWdata | input | 64 | New value |
| csrWmask | input | 64 | Bits to write |
| delegIn | input | 64 | Interrupt delegation mask toward the guest |
| mipIn | input | 64 | Current machine pending state |
| mieIn | input | 64 | Current machine enable state |
| csrRdata | output | 64 | Old value of the selected view |
| csrErr | output | 1 | Unknown CSR number |
| mipWrMask | output | 64 | Machine pending bits to update at the edge |
| mipWrData | output | 64 | New machine pending data |
| mieWrMask | output | 64 | Machine enable bits to update at the edge |
| mieWrData | output | 64 | New machine enable data |
| pendChanged | output | 1 | Separate pending storage is being written |

## Verification
The assertions assume that the owner of the machine pending and enable storage applies the side-port masks at the same edge that commits the block's own registers. They also assume that `delegIn` and the machine inputs are stable in each access cycle. The bench keeps that storage itself, updates it only from the side ports, and changes `delegIn` only between accesses. The strobe and no-change properties assume that reset is held for at least one edge before the first access, which the bench does.

// File: rtl/vsIrqPkg.sv
package vsIrqPkg;
  parameter int unsigned IRQ_W = 64;
  parameter int unsigned NUM_W = 12;
  parameter int unsigned FIRST_LOCAL = 13;
  parameter int unsigned GUEST_SOFT = 2;
  parameter int unsigned GUEST_TIMER = 6;
  parameter int unsigned GUEST_EXT = 10;

  localparam logic [IRQ_W-1:0] LOCAL_MASK = ~((IRQ_W'(1) << FIRST_LOCAL) - IRQ_W'(1));
  localparam logic [IRQ_W-1:0] VS_MASK = (IRQ_W'(1) << GUEST_SOFT) |
                                         (IRQ_W'(1) << GUEST_TIMER) |
                                         (IRQ_W'(1) << GUEST_EXT);
  localparam logic [IRQ_W-1:0] GVIEW_MASK = VS_MASK >> 1;
  localparam logic [IRQ_W-1:0] GPEND_WRITABLE = LOCAL_MASK | (IRQ_W'(1) << GUEST_SOFT);

  typedef struct packed {
    logic selVen;
    logic selVpend;
    logic selGpend;
    logic selGen;
    logic err;
  } csrStrobe_t;

  // guest view -> machine positions
  function automatic logic [IRQ_W-1:0] toNative(input logic [IRQ_W-1:0] g);
    return (g & ~(VS_MASK | GVIEW_MASK)) | ((g & GVIEW_MASK) << 1);
  endfunction

  // machine positions -> guest view
  function automatic logic [IRQ_W-1:0] toGuest(input logic [IRQ_W-1:0] n);
    return (n & ~(VS_MASK | GVIEW_MASK)) | ((n & VS_MASK) >> 1);
  endfunction
endpackage

// File: rtl/vsIrqCtrl.sv
module vsIrqCtrl
  import vsIrqPkg::*;
#(
  parameter logic [NUM_W-1:0] NUM_VEN   = 12'h608,
  parameter logic [NUM_W-1:0] NUM_VPEND = 12'h645,
  parameter logic [NUM_W-1:0] NUM_GEN   = 12'h204,
  parameter logic [NUM_W-1:0] NUM_GPEND = 12'h244
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrValid,
  input  logic [NUM_W-1:0] csrNum,
  output csrStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    if (csrValid) begin
      case (csrNum)
        NUM_VEN:   strobe.selVen = 1'b1;
        NUM_VPEND: strobe.selVpend = 1'b1;
        NUM_GEN:   strobe.selGen = 1'b1;
        NUM_GPEND: strobe.selGpend = 1'b1;
        default:   strobe.err = 1'b1;
      endcase
    end
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selVen, strobe.selVpend, strobe.selGen, strobe.selGpend, strobe.err}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrValid |-> (strobe == '0));
endmodule

// File: rtl/vsIrqData.sv
module vsIrqData
  import vsIrqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [IRQ_W-1:0] csrWdata,
  input  logic [IRQ_W-1:0] csrWmask,
  input  logic [IRQ_W-1:0] delegIn,
  input  logic [IRQ_W-1:0] mipIn,
  input  logic [IRQ_W-1:0] mieIn,
  output logic [IRQ_W-1:0] csrRdata,
  output logic [IRQ_W-1:0] mipWrMask,
  output logic [IRQ_W-1:0] mipWrData,
  output logic [IRQ_W-1:0] mieWrMask,
  output logic [IRQ_W-1:0] mieWrData,
  output logic             pendChanged
);
  logic [IRQ_W-1:0] venQ, vpendQ, gEnQ;
  logic [IRQ_W-1:0] venWm, vpendWm, vpendWd, gEnWm;
  logic [IRQ_W-1:0] aliasHv, sepBits, aliasGuest;
  logic [IRQ_W-1:0] nWd, nWm;

  always_comb begin
    // per-bit steering
    aliasHv    = VS_MASK | (LOCAL_MASK & (delegIn | ~venQ));
    sepBits    = LOCAL_MASK & ~delegIn & venQ;
    aliasGuest = (VS_MASK | LOCAL_MASK) & delegIn;
    nWd = toNative(csrWdata);
    nWm = toNative(csrWmask);

    csrRdata  = '0;
    mipWrMask = '0;
    mipWrData = csrWdata;
    mieWrMask = '0;
    mieWrData = nWd;
    venWm     = '0;
    vpendWm   = '0;
    vpendWd   = csrWdata;
    gEnWm     = '0;

    if (strobe.selVen) begin
      csrRdata = venQ;
      venWm    = csrWmask & LOCAL_MASK;
    end else if (strobe.selVpend) begin
      csrRdata  = (mipIn & aliasHv) | (vpendQ & sepBits);
      mipWrMask = csrWmask & aliasHv;
      vpendWm   = csrWmask & sepBits;
    end else if (strobe.selGpend) begin
      csrRdata  = toGuest((mipIn & aliasGuest) | (vpendQ & sepBits));
      mipWrMask = nWm & aliasGuest & GPEND_WRITABLE;
      mipWrData = nWd;
      vpendWm   = nWm & sepBits;
      vpendWd   = nWd;
    end else if (strobe.selGen) begin
      csrRdata  = toGuest(mieIn & aliasGuest) | (gEnQ & sepBits);
      mieWrMask = nWm & aliasGuest;
      gEnWm     = nWm & sepBits;
    end
    pendChanged = |vpendWm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      venQ   <= '0;
      vpendQ <= '0;
      gEnQ   <= '0;
    end else begin
      venQ   <= (venQ & ~venWm) | (csrWdata & venWm);
      vpendQ <= (vpendQ & ~vpendWm) | (vpendWd & vpendWm);
      gEnQ   <= (gEnQ & ~gEnWm) | (nWd & gEnWm);
    end
  end

  // R1
  ven_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    venQ[FIRST_LOCAL-1:0] == '0);

  // R8
  pend_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendChanged |=> $stable(vpendQ));

  // R2
  mip_reach_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mipWrMask & ~(VS_MASK | LOCAL_MASK)) == '0);

  // R10
  err_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |-> (mipWrMask == '0 && mieWrMask == '0));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |=> ($stable(venQ) && $stable(vpendQ) && $stable(gEnQ)));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWmask == '0) |=> ($stable(venQ) && $stable(vpendQ) && $stable(gEnQ)));
endmodule

// File: rtl/vsIrqCsr.sv
module vsIrqCsr
  import vsIrqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrValid,
  input  logic [NUM_W-1:0] csrNum,
  input  logic [IRQ_W-1:0] csrWdata,
  input  logic [IRQ_W-1:0] csrWmask,
  input  logic [IRQ_W-1:0] delegIn,
  input  logic [IRQ_W-1:0] mipIn,
  input  logic [IRQ_W-1:0] mieIn,
  output logic [IRQ_W-1:0] csrRdata,
  output logic             csrErr,
  output logic [IRQ_W-1:0] mipWrMask,
  output logic [IRQ_W-1:0] mipWrData,
  output logic [IRQ_W-1:0] mieWrMask,
  output logic [IRQ_W-1:0] mieWrData,
  output logic             pendChanged
);
  csrStrobe_t strobe;

  vsIrqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrNum(csrNum), .strobe(strobe)
  );

  vsIrqData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .csrWdata(csrWdata), .csrWmask(csrWmask), .delegIn(delegIn),
    .mipIn(mipIn), .mieIn(mieIn), .csrRdata(csrRdata),
    .mipWrMask(mipWrMask), .mipWrData(mipWrData),
    .mieWrMask(mieWrMask), .mieWrData(mieWrData), .pendChanged(pendChanged)
  );

  assign csrErr = strobe.err;
endmodule

// File: tb/sim_vsIrqCsr.sv
module sim_vsIrqCsr;
  localparam logic [11:0] VEN = 12'h608, VPEND = 12'h645, GEN = 12'h204, GPEND = 12'h244;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] LOC = 64'hFFFF_FFFF_FFFF_E000;
  localparam logic [63:0] DELEG1 = 64'h0000_0100_0000_0004;

  typedef struct {
    logic [63:0] rd;
    logic        err;
    logic        stb;
    string       tag;
  } item_t;

  logic clk = 0, rstN = 0, csrValid = 0;
  logic [11:0] csrNum = '0;
  logic [63:0] csrWdata = '0, csrWmask = '0, delegIn = '0;
  logic [63:0] mip, mie;
  logic [63:0] csrRdata, mipWrMask, mipWrData, mieWrMask, mieWrData;
  logic csrErr, pendChanged;
  int errors = 0, checks = 0;
  bit finished = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  vsIrqCsr u0 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrNum(csrNum),
    .csrWdata(csrWdata), .csrWmask(csrWmask), .delegIn(delegIn),
    .mipIn(mip), .mieIn(mie), .csrRdata(csrRdata), .csrErr(csrErr),
    .mipWrMask(mipWrMask), .mipWrData(mipWrData),
    .mieWrMask(mieWrMask), .mieWrData(mieWrData), .pendChanged(pendChanged)
  );

  // outside machine pending / enable storage
  always @(posedge clk) begin
    if (!rstN) begin
      mip <= '0;
      mie <= '0;
    end else begin
      mip <= (mip & ~mipWrMask) | (mipWrData & mipWrMask);
      mie <= (mie & ~mieWrMask) | (mieWrData & mieWrMask);
    end
  end

  task automatic op(input logic [11:0] n, input logic [63:0] wd, input logic [63:0] wm,
                    input logic [63:0] expRd, input logic expErr, input logic expStb,
                    input string tag);
    item_t it;
    @(negedge clk);
    csrValid = 1; csrNum = n; csrWdata = wd; csrWmask = wm;
    it.rd = expRd; it.err = expErr; it.stb = expStb; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idleCheck(input logic [63:0] act, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csrValid = 0; csrWmask = '0;
    #1;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares results against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (csrRdata !== it.rd || csrErr !== it.err || pendChanged !== it.stb) begin
          errors++;
          $display("FAIL %s: actual rd=%h err=%b stb=%b expected rd=%h err=%b stb=%b",
                   it.tag, csrRdata, csrErr, pendChanged, it.rd, it.err, it.stb);
        end
      end
    end
  end

  initial begin
    delegIn = DELEG1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    op(VEN, 0, 0, 0, 0, 0, "R11 enable mask after reset");
    op(GPEND, 0, 0, 0, 0, 0, "R11 guest pending after reset");
    op(VEN, ONES, ONES, 0, 0, 0, "R1 write enable mask");
    op(VEN, 0, 0, LOC, 0, 0, "R1 low bits read zero");
    op(VEN, 0, 64'h1 << 20, LOC, 0, 0, "R9 old value returned on write");
    op(VEN, 0, 0, 64'hFFFF_FFFF_FFEF_E000, 0, 0, "R9 update visible next cycle");
    op(VPEND, ONES, ONES, 0, 0, 1, "R8 strobe on separate pending write");
    op(VPEND, 0, 0, 64'hFFFF_FFFF_FFFF_E444, 0, 0, "R2 hypervisor pending read");
    idleCheck(mip, 64'h0000_0100_0010_0444, "R2 machine pending side port");
    op(GPEND, 0, 0, 64'hFFFF_FFFF_FFEF_E002, 0, 0, "R3 guest pending steering");
    op(GPEND, 0, ONES, 64'hFFFF_FFFF_FFEF_E002, 0, 1, "R6 guest pending clear");
    op(GPEND, 0, 0, 0, 0, 0, "R3 guest pending after clear");
    op(VPEND, 0, 0, 64'h0000_0000_0010_0440, 0, 0, "R5 undelegated VS bits untouched");
    op(GPEND, 64'h2, 64'h2, 0, 0, 0, "R4 guest bit 1 write");
    op(VPEND, 0, 0, 64'h0000_0000_0010_0444, 0, 0, "R4 lands at machine bit 2");
    op(GPEND, 0, 0, 64'h2, 0, 0, "R4 reads back at guest bit 1");
    op(GPEND, 0, 64'h220, 64'h2, 0, 0, "R5 write to undelegated guest bits");
    op(VPEND, 0, 0, 64'h0000_0000_0010_0444, 0, 0, "R5 machine bits 6 and 10 kept");
    op(VPEND, 64'h1BBB, 64'h1BBB, 64'h0000_0000_0010_0444, 0, 0, "R2 reserved low bits write");
    op(VPEND, 0, 0, 64'h0000_0000_0010_0444, 0, 0, "R2 reserved low bits ignored");
    op(GEN, ONES, ONES, 0, 0, 0, "R7 guest enable write");
    op(GEN, 0, 0, 64'hFFFF_FFFF_FFEF_E002, 0, 0, "R7 guest enable read");
    idleCheck(mie, 64'h0000_0100_0000_0004, "R7 machine enable side port");
    op(12'h123, ONES, ONES, 0, 1, 0, "R10 illegal number");
    op(VEN, 0, 0, 64'hFFFF_FFFF_FFEF_E000, 0, 0, "R10 enable mask unchanged");
    op(VPEND, 0, 0, 64'h0000_0000_0010_0444, 0, 0, "R10 pending unchanged");
    idleCheck(mie, 64'h0000_0100_0000_0004, "R10 machine enable unchanged");
    @(negedge clk);
    delegIn = '0;
    op(GEN, 0, 0, 64'hFFFF_FEFF_FFEF_E000, 0, 0, "R7 steering after delegation change");
    op(VPEND, 64'h1 << 40, 64'h1 << 40, 64'h0000_0000_0010_0444, 0, 1, "R3 bit 40 now separate");
    op(GPEND, 0, 0, 64'h0000_0100_0000_0000, 0, 0, "R3 guest sees separate bit, R5 bit 1 hidden");
    @(negedge clk);
    csrValid = 0; csrWmask = '0;
    repeat (3) @(negedge clk);
    finished = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule